// File: doc/BRIEF.md
# Recirculating Serial Word Store

This block keeps a fixed set of words in a loop of bit cells that shifts by one place on every clock. The bit leaving the end of the loop is fed back into its start, so the stored contents circulate and never stand still. One full trip around the loop is a major cycle. With the default parameters the loop holds 32 words of 32 bits, which is 1024 bit positions. A single tap, the access point, sees one stored bit per clock.

A client names a word and chooses read or write. The block then waits until the first bit of that word reaches the access point. For a read, it then copies 32 consecutive bits to a serial output and also feeds them back, so a read does not destroy the word. For a write, it puts the serial input bits into the loop in place of the circulating bits. Bits go out and come in least significant bit first.

The block reports how many cycles the request waited before its first data bit. That count depends only on where the requested word sat in the loop when the request arrived, and it can come close to one full major cycle.

Top module: `delay_line_store`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `req_ready` is 1 and `rd_valid`, `xfer_active`, `done` and `wait_count` are 0. Every stored bit reads back as 0 until it is written.
- R2: An internal position advances by one on every clock after reset and wraps from 1023 back to 0. In a cycle at position p, the bit at the access point belongs to word p/32, bit p%32.
- R3: A request is accepted at a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` then stays 0 until the cycle after `done`.
- R4: A transfer starts in the first cycle after acceptance in which the position equals `req_addr`*32. `xfer_active` is then 1 for exactly 32 consecutive cycles.
- R5: In the i-th active cycle of a write (i = 0..31), the value of `wr_bit` becomes bit i of the addressed word.
- R6: In the i-th active cycle of a read, `rd_valid` is 1 and `rd_bit` carries bit i of the addressed word. The word is unchanged afterwards, so reading it again returns the same value.
- R7: A write changes no other word. `wr_bit` has no effect outside the active cycles of a write.
- R8: After the first data bit, `wait_count` equals the number of cycles between acceptance and that bit: (addr*32 - (p+1)) mod 1024, where p is the position in the accepting cycle. The value is therefore never above 1023, and it holds until the next acceptance.
- R9: `done` is 1 only in the last (32nd) active cycle of a transfer, and it is 0 in the cycle that follows.
- R10: Stored words survive any number of major cycles with no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the loop shifts one place per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Word address of the request |
| req_ready | output | 1 | Block is idle and will accept a request |
| wr_bit | input | 1 | Serial write data, taken during active write cycles |
| rd_bit | output | 1 | Serial read data |
| rd_valid | output | 1 | `rd_bit` carries a bit of the addressed word |
| xfer_active | output | 1 | A data bit is transferred this cycle |
| done | output | 1 | Last bit of the transfer |
| wait_count | output | 10 | Cycles waited before the first data bit |

## Verification
Words are written with alternating patterns, with all ones, and with only the two end bits set. A word in one of these patterns exposes a bit-order reversal, while a stuck or shifted serial stream shows up across all of them. Neighbouring words and words at both address extremes are then read back to show that a write touches only its own slot, and a second read of the same word shows that reading does not destroy it. Requests are lined up with the position counter so that they wait zero cycles, the full 1023 cycles, and a count that crosses the wrap from 1023 to 0. This separates a correct modulo wait from an off-by-one or a missed wrap. A long idle stretch followed by reads confirms that contents last through many major cycles.

// File: rtl/dls_pkg.sv
// Shared types for the recirculating serial word store.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package dls_pkg;

    // Access controller phases: idle, waiting for the word, moving bits
    typedef enum logic [1:0] {
        ACC_IDLE = 2'd0,
        ACC_WAIT = 2'd1,
        ACC_XFER = 2'd2
    } acc_state_t;

endpackage

// File: rtl/dls_position_counter.sv
// Position counter: tracks which stored bit sits at the access point.
// The upper field is the passing word, the lower field the bit within it.
// Assumes: WORD_BITS and NUM_WORDS are powers of two.
module dls_position_counter #(
    parameter int WORD_BITS = 32,
    parameter int NUM_WORDS = 32
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    output logic [$clog2(NUM_WORDS)-1:0]          pos_word,
    output logic [$clog2(WORD_BITS)-1:0]          pos_bit
);
    localparam int TOTAL  = WORD_BITS * NUM_WORDS;
    localparam int POS_W  = $clog2(TOTAL);
    localparam int BIT_W  = $clog2(WORD_BITS);

    logic [POS_W-1:0] pos_q;

    // Advance one position per clock and wrap at the end of a major cycle
    always_ff @(posedge clk) begin
        if (!rst_n)
            pos_q <= '0;
        else if (pos_q == POS_W'(TOTAL - 1))
            pos_q <= '0;
        else
            pos_q <= pos_q + 1'b1;
    end

    // Split the position into word and bit fields
    always_comb begin
        pos_bit  = pos_q[BIT_W-1:0];
        pos_word = pos_q[POS_W-1:BIT_W];
    end

    AST_POS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (pos_q == (($past(pos_q) == POS_W'(TOTAL - 1)) ? '0 : $past(pos_q) + 1'b1))); // R2

endmodule

// File: rtl/dls_loop.sv
// Circulating bit loop: a ring of cells shifting one place per clock.
// cell 0 is the access point; its bit re-enters at the far end,
// replaced by the serial write bit when a write is in progress.
// Assumes: the controller raises wr_en only during write data cycles.
module dls_loop #(
    parameter int WORD_BITS = 32,
    parameter int NUM_WORDS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_bit,
    output logic tap_bit
);
    localparam int TOTAL = WORD_BITS * NUM_WORDS;

    logic [TOTAL-1:0] cells_q;
    logic             feed_bit;

    // Pick the bit that re-enters the loop this cycle
    always_comb begin
        tap_bit  = cells_q[0];
        feed_bit = wr_en ? wr_bit : cells_q[0];
    end

    // Rotate the loop; reset fills it with zeros
    always_ff @(posedge clk) begin
        if (!rst_n)
            cells_q <= '0;
        else
            cells_q <= {feed_bit, cells_q[TOTAL-1:1]};
    end

endmodule

// File: rtl/dls_access_ctrl.sv
// Access controller: latches a request and waits for the named word
// to reach the access point at bit 0. It then runs one word of serial
// transfer and counts the cycles spent waiting.
// Assumes: the position fields come from dls_position_counter.
module dls_access_ctrl
    import dls_pkg::*;
#(
    parameter int WORD_BITS = 32,
    parameter int NUM_WORDS = 32
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  req_valid,
    input  logic                                  req_write,
    input  logic [$clog2(NUM_WORDS)-1:0]          req_addr,
    input  logic [$clog2(NUM_WORDS)-1:0]          pos_word,
    input  logic [$clog2(WORD_BITS)-1:0]          pos_bit,
    output logic                                  req_ready,
    output logic                                  xfer_active,
    output logic                                  wr_en,
    output logic                                  rd_en,
    output logic                                  done,
    output logic [$clog2(WORD_BITS*NUM_WORDS)-1:0] wait_count
);
    localparam int TOTAL  = WORD_BITS * NUM_WORDS;
    localparam int POS_W  = $clog2(TOTAL);
    localparam int BIT_W  = $clog2(WORD_BITS);
    localparam int WORD_W = $clog2(NUM_WORDS);

    acc_state_t       state_q;
    logic [WORD_W-1:0] addr_q;
    logic             write_q;
    logic [POS_W-1:0] wait_q;
    logic             start_hit;
    logic             last_bit;

    // Detect the start boundary and the final bit of a word
    always_comb begin
        start_hit   = (state_q == ACC_WAIT) && (pos_word == addr_q) && (pos_bit == '0);
        last_bit    = (pos_bit == BIT_W'(WORD_BITS - 1));
        xfer_active = start_hit || (state_q == ACC_XFER);
        wr_en       = xfer_active && write_q;
        rd_en       = xfer_active && !write_q;
        done        = (state_q == ACC_XFER) && last_bit;
        req_ready   = (state_q == ACC_IDLE);
        wait_count  = wait_q;
    end

    // Sequence idle, wait and transfer phases
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ACC_IDLE;
            addr_q  <= '0;
            write_q <= 1'b0;
            wait_q  <= '0;
        end else begin
            unique case (state_q)
                ACC_IDLE: begin
                    if (req_valid) begin
                        state_q <= ACC_WAIT;
                        addr_q  <= req_addr;
                        write_q <= req_write;
                        wait_q  <= '0;
                    end
                end
                ACC_WAIT: begin
                    if (start_hit)
                        state_q <= ACC_XFER;
                    else
                        wait_q <= wait_q + 1'b1;
                end
                ACC_XFER: begin
                    if (last_bit)
                        state_q <= ACC_IDLE;
                end
                default: state_q <= ACC_IDLE;
            endcase
        end
    end

    AST_WAIT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ACC_WAIT && !start_hit) |-> (wait_q != POS_W'(TOTAL - 1))); // R8
    AST_XFER_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ACC_XFER) |-> (pos_bit == BIT_W'(1))); // R4
    AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R3
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready)); // R9

endmodule

// File: rtl/delay_line_store.sv
// Top level of the recirculating serial word store: a position counter,
// the circulating loop and the access controller.
// Assumes: one outstanding request at a time; wr_bit valid in write cycles.
module delay_line_store #(
    parameter int WORD_BITS = 32,
    parameter int NUM_WORDS = 32
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   req_valid,
    input  logic                                   req_write,
    input  logic [$clog2(NUM_WORDS)-1:0]           req_addr,
    output logic                                   req_ready,
    input  logic                                   wr_bit,
    output logic                                   rd_bit,
    output logic                                   rd_valid,
    output logic                                   xfer_active,
    output logic                                   done,
    output logic [$clog2(WORD_BITS*NUM_WORDS)-1:0] wait_count
);
    localparam int WORD_W = $clog2(NUM_WORDS);
    localparam int BIT_W  = $clog2(WORD_BITS);

    logic [WORD_W-1:0] pos_word;
    logic [BIT_W-1:0]  pos_bit;
    logic              wr_en;
    logic              rd_en;
    logic              tap_bit;

    dls_position_counter #(.WORD_BITS(WORD_BITS), .NUM_WORDS(NUM_WORDS)) pos_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pos_word (pos_word),
        .pos_bit  (pos_bit)
    );

    dls_loop #(.WORD_BITS(WORD_BITS), .NUM_WORDS(NUM_WORDS)) loop_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_bit  (wr_bit),
        .tap_bit (tap_bit)
    );

    dls_access_ctrl #(.WORD_BITS(WORD_BITS), .NUM_WORDS(NUM_WORDS)) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .pos_word    (pos_word),
        .pos_bit     (pos_bit),
        .req_ready   (req_ready),
        .xfer_active (xfer_active),
        .wr_en       (wr_en),
        .rd_en       (rd_en),
        .done        (done),
        .wait_count  (wait_count)
    );

    // Expose the tapped bit only while a read is moving data
    always_comb begin
        rd_valid = rd_en;
        rd_bit   = rd_en ? tap_bit : 1'b0;
    end

    AST_RD_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (xfer_active && !req_ready)); // R6

endmodule

// File: tb/delay_line_store_tb_top.sv
// Scoreboard bench: the driver task pushes expected read bits into a queue,
// and the monitor pops them as rd_valid pulses arrive.
module delay_line_store_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_write = 1'b0;
    logic [4:0] req_addr = '0;
    logic       wr_bit = 1'b0;
    logic       req_ready, rd_bit, rd_valid, xfer_active, done;
    logic [9:0] wait_count;

    int checks = 0;
    int failures = 0;
    int mpos = 0;
    bit exp_q[$];
    logic [31:0] mem [32];
    bit          wr_mode = 1'b0;
    logic [31:0] wr_data = '0;
    logic [15:0] junk = 16'hACE1;

    always #5 clk = ~clk;

    delay_line_store dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_ready(req_ready), .wr_bit(wr_bit), .rd_bit(rd_bit),
        .rd_valid(rd_valid), .xfer_active(xfer_active), .done(done), .wait_count(wait_count)
    );

    // Model of the position: one step per clock after reset (R2)
    always @(posedge clk) mpos <= rst_n ? ((mpos + 1) % 1024) : 0;

    // Serial write driver: data bit for the current position, else junk (R7)
    always @(negedge clk) begin
        junk   <= {junk[14:0], junk[15] ^ junk[13] ^ junk[12] ^ junk[10]};
        wr_bit <= wr_mode ? wr_data[mpos % 32] : junk[0];
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: compare each read bit with the scoreboard (R6)
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0)
                check(1'b0, "R6 unexpected bit", rd_bit, -1);
            else begin
                bit e;
                e = exp_q.pop_front();
                check(rd_bit == e, "R6 read bit", rd_bit, e);
            end
        end
    end

    // Driver: issue one access, optionally lined up with a position
    task automatic access(input bit wr, input int addr, input logic [31:0] data, input int align);
        int p0, exp_wait, active_n, first_pos, ready_bad;
        @(negedge clk);
        if (align >= 0) while (mpos != align) @(negedge clk);
        check(req_ready == 1'b1, "R3 ready when idle", req_ready, 1);
        req_valid = 1'b1; req_write = wr; req_addr = addr[4:0];
        p0 = mpos;
        if (wr) begin wr_data = data; wr_mode = 1'b1; end
        else for (int i = 0; i < 32; i++) exp_q.push_back(mem[addr][i]);
        exp_wait = ((addr * 32) - (p0 + 1) + 2048) % 1024;
        @(negedge clk);
        req_valid = 1'b0;
        active_n = 0; first_pos = -1; ready_bad = 0;
        forever begin
            if (req_ready) ready_bad++;
            if (xfer_active) begin
                if (active_n == 0) first_pos = mpos;
                active_n++;
            end
            if (done) break;
            @(negedge clk);
        end
        check(active_n == 32, "R4 active cycles", active_n, 32);
        check(first_pos == addr * 32, "R4 start position", first_pos, addr * 32);
        check(wait_count == 10'(exp_wait), "R8 wait count", wait_count, exp_wait);
        check(ready_bad == 0, "R3 ready low in transfer", ready_bad, 0);
        @(negedge clk);
        check(done == 1'b0 && req_ready == 1'b1, "R9 done single", done, 0);
        check(wait_count == 10'(exp_wait), "R8 wait held", wait_count, exp_wait);
        if (wr) begin mem[addr] = data; wr_mode = 1'b0; end
        else check(exp_q.size() == 0, "R6 all bits seen", exp_q.size(), 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) mem[i] = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(req_ready && !rd_valid && !xfer_active && !done && wait_count == 0,
              "R1 reset outputs", {req_ready, rd_valid, xfer_active, done}, 8);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !rd_valid && !xfer_active && wait_count == 0,
              "R1 after release", {req_ready, rd_valid, xfer_active}, 4);
        access(1'b0, 5, '0, -1);                       // R1 zeros
        access(1'b1, 5, 32'hA5C3_1F07, -1);            // R5
        access(1'b1, 31, 32'hFFFF_FFFF, -1);
        access(1'b1, 0, 32'h8000_0001, -1);
        access(1'b1, 6, 32'h1234_5678, -1);
        access(1'b0, 5, '0, -1);                       // R5
        access(1'b0, 4, '0, -1);                       // R7 neighbour
        access(1'b0, 6, '0, -1);
        access(1'b0, 31, '0, -1);
        access(1'b0, 0, '0, -1);
        access(1'b0, 5, '0, -1);                       // R6 second read
        access(1'b0, 0, '0, 0);                        // R8 wait 1023
        access(1'b0, 0, '0, 1023);                     // R8 wait 0 across wrap
        access(1'b0, 2, '0, 1000);                     // R8 wait across wrap
        access(1'b1, 9, 32'h5555_AAAA, 288);           // R8 full wait on write
        repeat (3000) @(negedge clk);                  // R10 idle major cycles
        access(1'b0, 9, '0, -1);                       // R10
        access(1'b0, 6, '0, -1);                       // R10
        access(1'b0, 31, '0, -1);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule